// File: doc/BRIEF.md
# Pseudo-Random Pattern Receive Synchronizer and Error Counter

This block watches a received serial bit stream and decides whether the stream carries a known pseudo-random test sequence. A reference shift register follows the stream. While the checker is out of sync, it loads each received bit into that register. Once in sync, the register runs on its own polynomial and predicts every bit, and each mismatch is a bit error. Two sequences can be selected: a 15-stage sequence with period 2^15-1, and a 20-stage sequence with period 2^20-1. The expected sequence can also be complemented before comparison.

Sync is decided once per window of 64 strobed bits. Mismatches are tallied over each window, and at the window's last bit the checker is in sync exactly when the tally is at most six. While in sync, bit errors are accumulated in a saturating counter, which a latch strobe snapshots and clears. A sticky status bit records lock transitions, either rising only or any change, and drives an interrupt line when that line is enabled.

Top module: `prbs_rx_checker`

## Requirements
- R1: With `std_sel`=0 the reference follows b[n]=b[n-15]^b[n-14] (15 stages). With `std_sel`=1 it follows b[n]=b[n-20]^b[n-17] (20 stages). A clean stream of the selected sequence gives `locked`=1 within two windows. A stream of the other sequence never gives `locked`=1.
- R2: Windows are consecutive groups of 64 strobed bits, counted from reset. `locked` changes only on the clock edge that takes a window's 64th bit. While unlocked, a window with 6 or fewer mismatches sets `locked`.
- R3: While locked, a window with 7 or more mismatches clears `locked`. A window with exactly 6 mismatches keeps it set.
- R4: With `pat_inv`=1 the complemented sequence is expected. A complemented stream locks only when `pat_inv`=1. With `pat_inv`=0 it drops lock at the next window end and stays unlocked.
- R5: While unlocked, the reference is loaded from the received bits. After a loss of lock, one clean window restores `locked` at that window's end.
- R6: A mismatch increments the error counter only while `locked`=1 and `cnt_sel`=2'b00. Mismatches seen while unlocked, or with any other `cnt_sel` value, leave the counter unchanged.
- R7: The error counter saturates at all ones of its width (0xFFFF at the default 16 bits) and does not wrap.
- R8: On the edge that samples `cnt_latch`=1, `err_count` takes the counter value and the counter is cleared.
- R9: With `any_edge`=0, `sync_sticky` is set one cycle after `locked` rises. A fall of `locked` does not set it. It holds until cleared.
- R10: With `any_edge`=1, both a rise and a fall of `locked` set `sync_sticky` one cycle later.
- R11: `sts_clr`=1 clears `sync_sticky` on the next edge. A qualifying transition in that same cycle wins, and the bit stays 1.
- R12: `irq` equals `sync_sticky` AND `irq_en`.
- R13: After reset, `locked`, `sync_sticky`, `irq` and `err_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_bit | input | 1 | Received data bit |
| rx_bit_en | input | 1 | Strobe: `rx_bit` is valid this cycle |
| std_sel | input | 1 | Sequence select: 0 = 15-stage, 1 = 20-stage |
| pat_inv | input | 1 | Expect the complemented sequence |
| any_edge | input | 1 | Sticky mode: 0 = lock rise only, 1 = any lock change |
| irq_en | input | 1 | Interrupt enable |
| cnt_sel | input | 2 | Error source select; counting only at 2'b00 |
| sts_clr | input | 1 | Clear strobe for the sticky status |
| cnt_latch | input | 1 | Snapshot-and-clear strobe for the error counter |
| locked | output | 1 | Pattern sync status |
| sync_sticky | output | 1 | Sticky record of lock transitions |
| irq | output | 1 | Interrupt request |
| err_count | output | CNT_W | Latched error count |

## Verification
The checker is driven with several streams. A clean stream in each sequence shows that the selected polynomial is the one followed. A stream in the other sequence, and a complemented stream with inversion off, show that a wrong reference never locks. Windows with exactly six and with seven flipped bits separate the threshold on both sides and give exact error counts. Long runs of six errors per window reach the saturation point, and the sticky status is exercised in both edge modes, including a clear that coincides with a transition.

// File: rtl/prbs_rx_pkg.sv
// Shared types and the sequence predictor for the pattern receive checker.
// Assumes the reference history keeps the newest bit at index 0.
package prbs_rx_pkg;

    typedef enum logic {
        SEQ_15 = 1'b0,
        SEQ_20 = 1'b1
    } seq_sel_e;

    localparam int HIST_W = 20;

    // Next expected bit from the history for the selected recurrence.
    function automatic logic predict_bit(input logic [HIST_W-1:0] hist, input seq_sel_e sel);
        if (sel == SEQ_15) begin
            return hist[14] ^ hist[13];
        end
        return hist[19] ^ hist[16];
    endfunction

endpackage

// File: rtl/prbs_ref_track.sv
// Reference tracker: while unlocked, each strobed bit is loaded into the
// history; while locked, the history advances on its own prediction.
// Flags a mismatch between the received bit and the (possibly inverted)
// prediction. Assumes one bit per strobe.
module prbs_ref_track
    import prbs_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     bit_en,
    input  logic     rx_bit,
    input  logic     inv,
    input  seq_sel_e seq,
    input  logic     locked,
    output logic     bit_err
);

    logic [HIST_W-1:0] hist_q;
    logic              pred;
    logic              rx_norm;

    // Prediction and comparison in the non-inverted domain.
    always_comb begin
        pred    = predict_bit(hist_q, seq);
        rx_norm = rx_bit ^ inv;
        bit_err = bit_en & (rx_norm != pred);
    end

    // History update: self-seed when unlocked, free-run when locked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (bit_en) begin
            hist_q <= {hist_q[HIST_W-2:0], (locked ? pred : rx_norm)};
        end
    end

endmodule

// File: rtl/prbs_sync_fsm.sv
// Window-based lock decision: counts strobed bits in consecutive windows of
// WIN_LEN, tallies mismatches, and at each window's last bit sets lock when
// the tally is at most ERR_LIMIT. Assumes WIN_LEN is a power of two >= 2.
module prbs_sync_fsm #(
    parameter int WIN_LEN   = 64,
    parameter int ERR_LIMIT = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic bit_err,
    output logic locked,
    output logic win_end
);

    localparam int WIN_CW  = $clog2(WIN_LEN);
    localparam int TALLY_W = $clog2(WIN_LEN + 1);
    localparam logic [WIN_CW-1:0]  LAST_POS = WIN_CW'(WIN_LEN - 1);
    localparam logic [TALLY_W-1:0] LIMIT_T  = TALLY_W'(ERR_LIMIT);

    logic [WIN_CW-1:0]  pos_q;
    logic [TALLY_W-1:0] tally_q;
    logic [TALLY_W-1:0] total;

    // Window end marker and the tally including the current bit.
    always_comb begin
        win_end = bit_en && (pos_q == LAST_POS);
        total   = tally_q + TALLY_W'(bit_err);
    end

    // Bit position within the current window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (bit_en) begin
            pos_q <= win_end ? '0 : pos_q + 1'b1;
        end
    end

    // Mismatch tally, restarted at each window boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tally_q <= '0;
        end else if (bit_en) begin
            tally_q <= win_end ? '0 : total;
        end
    end

    // Lock decision, made only at a window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked <= 1'b0;
        end else if (win_end) begin
            locked <= (total <= LIMIT_T);
        end
    end

    AST_LOCK_AT_WINDOW_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(locked) |-> $past(win_end)); // R2

endmodule

// File: rtl/prbs_err_accum.sv
// Saturating bit-error counter with snapshot-and-clear. Counts mismatches
// only while locked and when the source select is 2'b00. Assumes the latch
// strobe is a single-cycle pulse.
module prbs_err_accum #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_err,
    input  logic             locked,
    input  logic [1:0]       cnt_sel,
    input  logic             latch,
    output logic [CNT_W-1:0] count_q
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             inc;

    // Qualified increment request.
    always_comb begin
        inc = bit_err && locked && (cnt_sel == 2'b00);
    end

    // Running counter: cleared by a latch, saturates at all ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (latch) begin
            cnt_q <= inc ? CNT_W'(1) : '0;
        end else if (inc && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Output snapshot taken on a latch strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (latch) begin
            count_q <= cnt_q;
        end
    end

    AST_NO_COUNT_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(locked) && !$past(latch)) |-> $stable(cnt_q)); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt_q) == CNT_MAX && !$past(latch)) |-> (cnt_q == CNT_MAX)); // R7

endmodule

// File: rtl/prbs_sync_irq.sv
// Sticky status and interrupt for lock transitions. In rise-only mode only
// a 0-to-1 change of lock is captured; otherwise any change is. A capture in
// the same cycle as a clear wins. Assumes lock is a registered signal.
module prbs_sync_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic locked,
    input  logic any_edge,
    input  logic clr,
    input  logic irq_en,
    output logic sticky,
    output logic irq
);

    logic locked_d;
    logic evt;

    // Transition detection against the delayed lock copy.
    always_comb begin
        if (any_edge) begin
            evt = locked ^ locked_d;
        end else begin
            evt = locked & ~locked_d;
        end
        irq = sticky & irq_en;
    end

    // One-cycle delayed lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_d <= 1'b0;
        end else begin
            locked_d <= locked;
        end
    end

    // Sticky bit: set by an event, cleared by a clear, event first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky <= 1'b0;
        end else if (evt) begin
            sticky <= 1'b1;
        end else if (clr) begin
            sticky <= 1'b0;
        end
    end

    AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sticky) && !$past(clr)) |-> sticky); // R9
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clr) && !$past(evt)) |-> !sticky); // R11

endmodule

// File: rtl/prbs_rx_checker.sv
// Top of the pattern receive checker: reference tracker, window lock
// decision, saturating error counter and sticky interrupt status.
// Assumes rx_bit is sampled only when rx_bit_en is high.
module prbs_rx_checker
    import prbs_rx_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int WIN_LEN   = 64,
    parameter int ERR_LIMIT = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_bit,
    input  logic             rx_bit_en,
    input  logic             std_sel,
    input  logic             pat_inv,
    input  logic             any_edge,
    input  logic             irq_en,
    input  logic [1:0]       cnt_sel,
    input  logic             sts_clr,
    input  logic             cnt_latch,
    output logic             locked,
    output logic             sync_sticky,
    output logic             irq,
    output logic [CNT_W-1:0] err_count
);

    logic     bit_err;
    logic     win_end;
    seq_sel_e seq;

    // Sequence select as the shared enum.
    always_comb begin
        seq = seq_sel_e'(std_sel);
    end

    prbs_ref_track u_ref (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (rx_bit_en),
        .rx_bit  (rx_bit),
        .inv     (pat_inv),
        .seq     (seq),
        .locked  (locked),
        .bit_err (bit_err)
    );

    prbs_sync_fsm #(
        .WIN_LEN   (WIN_LEN),
        .ERR_LIMIT (ERR_LIMIT)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (rx_bit_en),
        .bit_err (bit_err),
        .locked  (locked),
        .win_end (win_end)
    );

    prbs_err_accum #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_err (bit_err),
        .locked  (locked),
        .cnt_sel (cnt_sel),
        .latch   (cnt_latch),
        .count_q (err_count)
    );

    prbs_sync_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .locked   (locked),
        .any_edge (any_edge),
        .clr      (sts_clr),
        .irq_en   (irq_en),
        .sticky   (sync_sticky),
        .irq      (irq)
    );

    AST_LOCK_CHANGE_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(locked)) |-> $past(rx_bit_en)); // R2

endmodule

// File: tb/tb_prbs_rx_checker.sv
`timescale 1ns/1ps
module tb_prbs_rx_checker;

    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_bit = 1'b0;
    logic          rx_bit_en = 1'b0;
    logic          std_sel = 1'b0;
    logic          pat_inv = 1'b0;
    logic          any_edge = 1'b0;
    logic          irq_en = 1'b1;
    logic [1:0]    cnt_sel = 2'b00;
    logic          sts_clr = 1'b0;
    logic          cnt_latch = 1'b0;
    logic          locked;
    logic          sync_sticky;
    logic          irq;
    logic [CW-1:0] err_count;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    logic [19:0] hist = 20'hABCDE;
    logic        gen_sel = 1'b0;
    logic        gen_inv = 1'b0;

    always #4 clk = ~clk;

    prbs_rx_checker #(.CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_bit_en(rx_bit_en),
        .std_sel(std_sel), .pat_inv(pat_inv), .any_edge(any_edge), .irq_en(irq_en),
        .cnt_sel(cnt_sel), .sts_clr(sts_clr), .cnt_latch(cnt_latch),
        .locked(locked), .sync_sticky(sync_sticky), .irq(irq), .err_count(err_count)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Next bit of the bench's own sequence from its recurrence.
    function automatic logic gen_next();
        logic b;
        b = gen_sel ? (hist[19] ^ hist[16]) : (hist[14] ^ hist[13]);
        hist = {hist[18:0], b};
        return b;
    endfunction

    task automatic send_bit(input logic b);
        @(negedge clk);
        rx_bit = b;
        rx_bit_en = 1'b1;
        @(posedge clk);
        #1;
        rx_bit_en = 1'b0;
    endtask

    // One 64-bit window with nerr flipped bits.
    task automatic send_window(input int nerr);
        int flips = 0;
        for (int i = 0; i < 64; i++) begin
            logic b;
            b = gen_next() ^ gen_inv;
            if ((i % 8 == 3) && (flips < nerr)) begin
                b = ~b;
                flips++;
            end
            send_bit(b);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_latch();
        @(negedge clk);
        cnt_latch = 1'b1;
        @(posedge clk);
        #1;
        cnt_latch = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        sts_clr = 1'b1;
        @(posedge clk);
        #1;
        sts_clr = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);
        // R13 reset state
        chk("R13 locked", locked, 0);
        chk("R13 sticky", sync_sticky, 0);
        chk("R13 irq", irq, 0);
        chk("R13 count", err_count, 0);

        // R1 R2 acquisition on the 15-stage sequence
        send_window(0);
        send_window(0);
        chk("R1 lock on 15-stage", locked, 1);
        idle(2);
        chk("R9 sticky on rise", sync_sticky, 1);
        chk("R12 irq enabled", irq, 1);
        pulse_latch();
        chk("R6 no count while unlocked", err_count, 0);

        irq_en = 1'b0;
        idle(1);
        chk("R12 irq masked", irq, 0);
        chk("R9 sticky holds", sync_sticky, 1);
        irq_en = 1'b1;
        pulse_clr();
        chk("R11 clear", sync_sticky, 0);

        // R3 boundary: exactly six errors keep lock
        send_window(6);
        chk("R3 six keeps lock", locked, 1);
        pulse_latch();
        chk("R6 count six", err_count, 6);

        // R6 other select value does not count
        cnt_sel = 2'b01;
        send_window(5);
        pulse_latch();
        chk("R6 sel01 no count", err_count, 0);
        cnt_sel = 2'b00;

        // R3 seven errors drop lock
        send_window(7);
        chk("R3 seven drops lock", locked, 0);
        idle(2);
        chk("R9 fall ignored", sync_sticky, 0);
        pulse_latch();
        chk("R6 seven counted", err_count, 7);

        // R5 re-seed after loss
        send_window(0);
        chk("R5 relock one window", locked, 1);
        idle(2);
        chk("R9 sticky on relock", sync_sticky, 1);
        pulse_clr();

        // R10 R11 any-change mode, clear coincident with the fall event
        any_edge = 1'b1;
        send_window(7);
        chk("R3 drop again", locked, 0);
        pulse_clr();
        chk("R11 event beats clear", sync_sticky, 1);
        pulse_clr();
        chk("R11 later clear", sync_sticky, 0);
        send_window(0);
        idle(2);
        chk("R10 rise captured", sync_sticky, 1);
        pulse_clr();
        send_window(7);
        idle(2);
        chk("R10 fall captured", sync_sticky, 1);
        pulse_clr();
        send_window(0);
        chk("R5 relock", locked, 1);

        // R7 R8 saturation and clear
        pulse_latch();
        for (int w = 0; w < 43; w++) send_window(6);
        chk("R7 still locked", locked, 1);
        pulse_latch();
        chk("R7 saturates", err_count, 255);
        pulse_latch();
        chk("R8 counter cleared", err_count, 0);

        // R4 complemented stream
        gen_inv = 1'b1;
        send_window(0);
        send_window(0);
        send_window(0);
        chk("R4 no lock without inversion", locked, 0);
        pat_inv = 1'b1;
        send_window(0);
        send_window(0);
        chk("R4 lock with inversion", locked, 1);

        // R1 wrong sequence never locks, right one does
        std_sel = 1'b1;
        send_window(0);
        send_window(0);
        send_window(0);
        chk("R1 wrong sequence unlocked", locked, 0);
        gen_sel = 1'b1;
        send_window(0);
        send_window(0);
        chk("R1 lock on 20-stage", locked, 1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule